// File: doc/BRIEF.md
# Address Disambiguation Tracking Matrix

This block sits beside a memory order buffer and tells each buffer slot whether every memory operation allocated before it has resolved its address. The block keeps a square bit matrix with one row and one column per slot. A 1 in row i, column j means that slot j is older than slot i and its address is still unknown. Three single-index event strobes drive the matrix, plus a flush:
- **Allocate** writes a new row. It is a snapshot of every slot that is still pending.
- **Resolve** clears one column.
- **Free** clears one slot's row and its column.
- **Flush** empties everything.

The per-slot output is the registered NOR of the slot's row. A load slot that is waiting for completion uses it to learn that its ordering-violation flag can no longer change. The slot can then mark itself complete in the reorder buffer. Results may be broadcast before that point, in any order. Only the completion mark waits on this signal.

Resolution is tracked pairwise and does not depend on commit. A load therefore never waits for an older store to commit. This matters when the reorder buffer retires whole fetch groups, because the load itself can hold up that commit.

Top module: `disamb_matrix`

## Requirements
- R1: After a synchronous reset, `older_resolved` is all ones.
- R2: One cycle after an allocation of slot i, `older_resolved[i]` is 1 exactly when no other slot is allocated with its address unresolved.
- R3: A resolve of slot j removes j as a blocker from every row at the same clock edge. Each affected slot's output rises in that cycle if j was its last blocker.
- R4: Resolves may arrive in any order. A slot's output rises only after every older slot has resolved or been freed. Whether those older slots have committed has no effect.
- R5: A slot allocated later never clears a set output bit of an already allocated slot. Only an allocation of slot i can drive `older_resolved[i]` from 1 to 0.
- R6: When an allocation and a resolve occur in the same cycle, the resolving slot is not recorded as a blocker of the new slot.
- R7: Freeing slot k clears its row and its column. Slots blocked only by k then report 1, and `older_resolved[k]` reads 1 until k is reallocated. A free in the same cycle as an allocation keeps the freed slot out of the new row.
- R8: `flush` empties the matrix and the pending set. An allocation strobe in the same cycle is ignored, so afterwards every output reads 1 and a new allocation sees no blockers.
- R9: A reused slot index counts by allocation age, not by index. When a freed index is reallocated, it blocks only slots allocated after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Allocate strobe |
| alloc_idx | input | IW | Slot being allocated |
| resolve_vld | input | 1 | Address-resolved strobe |
| resolve_idx | input | IW | Slot whose address became known |
| free_vld | input | 1 | Free or squash strobe |
| free_idx | input | IW | Slot being released |
| flush | input | 1 | Clear all tracking state |
| older_resolved | output | N | Per slot: all older operations have known addresses |

## Verification
The hardest situation to reach from the ports is a slot index that is reused while slots older and younger than the new occupant are still pending. This case needs a free, a reallocation and out-of-order resolves, all interleaved. Directed tasks build that case by hand and also drive the same-cycle allocate/resolve and allocate/free collisions. A long pseudo-random run then issues only legal strobes chosen by an LFSR. After every cycle, it compares all outputs against a model that compares allocation sequence numbers and ignores indices.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int unsigned DM_DEF_SLOTS = 16;

  // decoded event kinds seen by the matrix in one cycle
  typedef struct packed {
    logic flush;
    logic alloc;
    logic resolve;
    logic free;
  } dm_ctl_t;
endpackage

// File: rtl/dm_dec.sv
module dm_dec #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          en,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  oh
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    assign oh[k] = en && (idx == IW'(k));
  end
endmodule

// File: rtl/dm_row.sv
module dm_row #(
  parameter int unsigned N   = 16,
  parameter int unsigned ROW = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wipe,
  input  logic         load,
  input  logic [N-1:0] snap,
  input  logic [N-1:0] clr_col,
  input  logic         clr_row,
  output logic         ready_q
);
  logic [N-1:0] row_q, row_d;

  always_comb begin
    if (wipe)         row_d = '0;
    else if (load)    row_d = snap;
    else if (clr_row) row_d = '0;
    else              row_d = row_q & ~clr_col;
    row_d[ROW] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q   <= '0;
      ready_q <= 1'b1;
    end else begin
      row_q   <= row_d;
      ready_q <= ~|row_d;
    end
  end
endmodule

// File: rtl/disamb_matrix.sv
module disamb_matrix
  import dm_pkg::*;
#(
  parameter int unsigned N  = DM_DEF_SLOTS,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_vld,
  input  logic [IW-1:0] alloc_idx,
  input  logic          resolve_vld,
  input  logic [IW-1:0] resolve_idx,
  input  logic          free_vld,
  input  logic [IW-1:0] free_idx,
  input  logic          flush,
  output logic [N-1:0]  older_resolved
);
  dm_ctl_t      ctl;
  logic [N-1:0] alloc_oh, res_oh, free_oh;
  logic [N-1:0] pend_q, pend_d, snap, clr_col;

  assign ctl = '{flush: flush, alloc: alloc_vld && !flush,
                 resolve: resolve_vld && !flush, free: free_vld && !flush};

  dm_dec #(.N(N), .IW(IW)) u_dec_alloc (.en(ctl.alloc),   .idx(alloc_idx),   .oh(alloc_oh));
  dm_dec #(.N(N), .IW(IW)) u_dec_res   (.en(ctl.resolve), .idx(resolve_idx), .oh(res_oh));
  dm_dec #(.N(N), .IW(IW)) u_dec_free  (.en(ctl.free),    .idx(free_idx),    .oh(free_oh));

  assign clr_col = res_oh | free_oh;
  // new row: slots still pending after this cycle's resolve/free, never itself
  assign snap    = pend_q & ~clr_col & ~alloc_oh;

  always_comb begin
    if (ctl.flush) pend_d = '0;
    else           pend_d = (pend_q & ~clr_col) | alloc_oh;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    dm_row #(.N(N), .ROW(r)) u_row (
      .clk     (clk),
      .rst     (rst),
      .wipe    (ctl.flush),
      .load    (alloc_oh[r]),
      .snap    (snap),
      .clr_col (clr_col),
      .clr_row (free_oh[r]),
      .ready_q (older_resolved[r])
    );
  end
endmodule

// File: rtl/disamb_matrix_chk.sv
module disamb_matrix_chk #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic          alloc_vld,
  input logic [IW-1:0] alloc_idx,
  input logic          resolve_vld,
  input logic [IW-1:0] resolve_idx,
  input logic          free_vld,
  input logic [IW-1:0] free_idx,
  input logic          flush,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  older_resolved
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&older_resolved && pend_q == '0));

  p_alloc_unblocked_r2: assert property (@(posedge clk) disable iff (rst)
    (alloc_vld && !flush && pend_q == '0) |=> older_resolved[$past(alloc_idx)]);

  p_resolve_drops_r3: assert property (@(posedge clk) disable iff (rst)
    (resolve_vld && !flush && !(alloc_vld && alloc_idx == resolve_idx))
      |=> !pend_q[$past(resolve_idx)]);

  p_no_fall_r5: assert property (@(posedge clk) disable iff (rst)
    !alloc_vld |=> ((~older_resolved & $past(older_resolved)) == '0));

  p_single_fall_r5: assert property (@(posedge clk) disable iff (rst)
    alloc_vld |=> ($countones(~older_resolved & $past(older_resolved)) <= 1));

  p_free_releases_r7: assert property (@(posedge clk) disable iff (rst)
    (free_vld && !flush && !(alloc_vld && alloc_idx == free_idx))
      |=> (!pend_q[$past(free_idx)] && older_resolved[$past(free_idx)]));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (pend_q == '0 && &older_resolved));
endmodule

bind disamb_matrix disamb_matrix_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
  .resolve_vld(resolve_vld), .resolve_idx(resolve_idx),
  .free_vld(free_vld), .free_idx(free_idx), .flush(flush),
  .pend_q(pend_q), .older_resolved(older_resolved)
);

// File: tb/tb_disamb_matrix.sv
module tb_disamb_matrix;
  localparam int N  = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_vld = 0, resolve_vld = 0, free_vld = 0, flush = 0;
  logic [IW-1:0] alloc_idx = '0, resolve_idx = '0, free_idx = '0;
  logic [N-1:0] older_resolved;

  int n_chk = 0, n_bad = 0;

  // model: per slot valid, unresolved, allocation sequence number
  logic m_val [N];
  logic m_unr [N];
  int   m_seq [N];
  int   seq_ctr = 0;

  always #2 clk = ~clk;

  disamb_matrix #(.N(N), .IW(IW)) dut (
    .clk(clk), .rst(rst), .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
    .resolve_vld(resolve_vld), .resolve_idx(resolve_idx),
    .free_vld(free_vld), .free_idx(free_idx), .flush(flush),
    .older_resolved(older_resolved)
  );

  function automatic logic [N-1:0] expect_vec();
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) begin
      e[i] = 1'b1;
      if (m_val[i])
        for (int j = 0; j < N; j++)
          if (j != i && m_val[j] && m_unr[j] && m_seq[j] < m_seq[i]) e[i] = 1'b0;
    end
    return e;
  endfunction

  task automatic check(input string req);
    logic [N-1:0] e;
    e = expect_vec();
    n_chk++;
    if (older_resolved !== e) begin
      n_bad++;
      $display("FAIL %s: older_resolved=%h expected=%h", req, older_resolved, e);
    end
  endtask

  // called at a negedge; drives one cycle of strobes, then checks at next negedge
  task automatic step(input logic av, input int ai, input logic rv, input int ri,
                      input logic fv, input int fi, input logic fl, input string req);
    alloc_vld = av;   alloc_idx = IW'(ai);
    resolve_vld = rv; resolve_idx = IW'(ri);
    free_vld = fv;    free_idx = IW'(fi);
    flush = fl;
    @(negedge clk);
    alloc_vld = 0; resolve_vld = 0; free_vld = 0; flush = 0;
    if (fl) begin
      for (int i = 0; i < N; i++) begin m_val[i] = 0; m_unr[i] = 0; end
    end else begin
      if (rv) m_unr[ri] = 0;
      if (fv) begin m_val[fi] = 0; m_unr[fi] = 0; end
      if (av) begin m_val[ai] = 1; m_unr[ai] = 1; m_seq[ai] = seq_ctr++; end
    end
    check(req);
  endtask

  task automatic alloc(input int i, input string req);   step(1, i, 0, 0, 0, 0, 0, req); endtask
  task automatic resolve(input int j, input string req); step(0, 0, 1, j, 0, 0, 0, req); endtask
  task automatic free(input int k, input string req);    step(0, 0, 0, 0, 1, k, 0, req); endtask

  task automatic t_reset();
    check("R1");
    if (older_resolved !== '1) begin
      n_bad++; $display("FAIL R1: older_resolved=%h expected=%h", older_resolved, {N{1'b1}});
    end
    n_chk++;
  endtask

  task automatic t_alloc_chain();
    alloc(0, "R2"); alloc(1, "R2"); alloc(2, "R2");
  endtask

  task automatic t_out_of_order();
    resolve(2, "R4"); resolve(0, "R3"); resolve(1, "R4");
  endtask

  task automatic t_younger();
    alloc(3, "R5"); alloc(4, "R5"); alloc(11, "R5");
  endtask

  task automatic t_same_cycle();
    resolve(11, "R6");
    step(1, 5, 1, 4, 0, 0, 0, "R6");
    resolve(3, "R6"); resolve(5, "R6");
  endtask

  task automatic t_free();
    alloc(3, "R7"); alloc(5, "R7"); alloc(6, "R7");
    free(3, "R7");
    step(1, 7, 0, 0, 1, 5, 0, "R7");
    resolve(6, "R7"); resolve(7, "R7");
  endtask

  task automatic t_reuse();
    free(0, "R9"); free(1, "R9");
    alloc(8, "R9"); alloc(9, "R9");
    alloc(0, "R9");
    free(2, "R9"); alloc(2, "R9");
    resolve(9, "R9"); resolve(8, "R9"); resolve(0, "R9"); resolve(2, "R9");
  endtask

  task automatic t_flush();
    alloc(12, "R8");
    step(1, 13, 0, 0, 0, 0, 1, "R8");
    alloc(10, "R8");
    if (older_resolved[10] !== 1'b1) begin
      n_bad++; $display("FAIL R8: older_resolved[10]=%b expected=1", older_resolved[10]);
    end
    n_chk++;
    step(0, 0, 0, 0, 0, 0, 1, "R8");
  endtask

  task automatic t_stress();
    logic [15:0] lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      logic av, rv, fv, fl;
      int ai, ri, fi;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ai = int'(lf[3:0]); ri = int'(lf[7:4]); fi = int'(lf[11:8]);
      av = !m_val[ai];
      rv = m_val[ri] && m_unr[ri] && !(av && ri == ai);
      fv = lf[12] && m_val[fi] && !(av && fi == ai);
      fl = (lf[15:13] == 3'b111) && (lf[2:0] == 3'b000);
      step(av, ai, rv, ri, fv, fi, fl, "R3");
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_unr[i] = 0; m_seq[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_alloc_chain();
    t_out_of_order();
    t_younger();
    t_same_cycle();
    t_free();
    t_reuse();
    t_flush();
    t_stress();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run incomplete, expected finish before timeout");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule